// File: doc/BRIEF.md
# Narrow Edge Filter Datapath

This block applies the short four-tap smoothing step across a block edge. It takes the two pixels on each side of the edge (outer and inner on the near side, inner and outer on the far side), a high-variance flag and a filter enable. It returns the four adjusted pixels. A mode input selects 10-bit or 12-bit pixels. The mode sets the signed saturation bounds used by every intermediate value and the unsigned range to which each result is clamped.

A correction term is first built from the difference across the edge. When the variance flag is set, the outer-tap difference is added to this term. The inner pixels then move toward each other by two rounded fractions of the term. The outer pixels move by half of the inner step, but only when the variance flag is clear. The datapath has two register stages and carries a valid bit alongside the data. One new pixel set can enter on every cycle.

Top module: `edge4_filter`

## Requirements
- R1: A set presented with `in_valid` high before clock edge k appears on the outputs with `out_valid` high after edge k+1, which is two edges of latency. While reset (`rst_n` low) is asserted, `out_valid` and all four output pixels read 0.
- R2: Intermediate values saturate to the signed range -512..511 when `mode12`=0 and to -2048..2047 when `mode12`=1.
- R3: The base term is sat(p1 - q1) when `hev`=1 and 0 when `hev`=0.
- R4: The term is f = sat(3*(q0 - p0) + base). It is forced to 0 when `enable`=0, and the four outputs then equal the four inputs.
- R5: With f1 = min(f+4, max) >>> 3 and f2 = min(f+3, max) >>> 3, where max is the mode's positive bound and >>> is an arithmetic shift, q0 becomes q0 - f1 and p0 becomes p0 + f2.
- R6: When `hev`=0, p1 gains a = (f1+1) >>> 1 and q1 loses a. When `hev`=1, p1 and q1 pass through unchanged.
- R7: Each output pixel is clamped to 0..1023 when `mode12`=0 and to 0..4095 when `mode12`=1.
- R8: Sets presented on consecutive cycles are processed independently. A cycle with `in_valid` low gives a cycle with `out_valid` low two edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input set is valid |
| mode12 | input | 1 | 1 selects 12-bit pixels, 0 selects 10-bit |
| hev | input | 1 | High edge variance flag |
| enable | input | 1 | Narrow filter enable |
| p1_i | input | 12 | Outer pixel, near side |
| p0_i | input | 12 | Inner pixel, near side |
| q0_i | input | 12 | Inner pixel, far side |
| q1_i | input | 12 | Outer pixel, far side |
| out_valid | output | 1 | Output set is valid |
| p1_o | output | 12 | Filtered outer pixel, near side |
| p0_o | output | 12 | Filtered inner pixel, near side |
| q0_o | output | 12 | Filtered inner pixel, far side |
| q1_o | output | 12 | Filtered outer pixel, far side |

## Verification
Every result is due two clock edges after its inputs are applied. The valid bit, the four pixels and the bubble cycles all share that latency. The bench drives a new set on each falling edge and pushes the expected values into a two-slot shift register. On each falling edge it first compares the outputs against the oldest slot and only then drives the next set, so each comparison lands exactly two edges after its stimulus. Random sets in both modes are mixed with directed saturation and clamp cases, and these include back-to-back sets and bubbles.

// File: rtl/edge4_pkg.sv
package edge4_pkg;
    parameter int PIX_W    = 12;            // widest pixel
    parameter int NARROW_W = PIX_W - 2;     // narrow pixel mode width
    parameter int INT_W    = 16;            // signed intermediate width
    parameter int SHIFT_F  = 3;

    typedef logic signed [INT_W-1:0] sint_t;
    typedef logic [PIX_W-1:0]        pix_t;

    localparam sint_t HI_WIDE   = sint_t'((1 <<< (PIX_W-1)) - 1);
    localparam sint_t HI_NARROW = sint_t'((1 <<< (NARROW_W-1)) - 1);
    localparam sint_t PIX_MAX_W = sint_t'((1 <<< PIX_W) - 1);
    localparam sint_t PIX_MAX_N = sint_t'((1 <<< NARROW_W) - 1);

    typedef struct packed {
        logic  vld;
        logic  wide;
        logic  hev;
        sint_t f;
        pix_t  p1;
        pix_t  p0;
        pix_t  q0;
        pix_t  q1;
    } term_t;

    typedef struct packed {
        logic vld;
        logic wide;
        pix_t p1;
        pix_t p0;
        pix_t q0;
        pix_t q1;
    } pix_set_t;

    function automatic sint_t widen(input pix_t v);
        return sint_t'({{(INT_W-PIX_W){1'b0}}, v});
    endfunction

    function automatic sint_t pos_bound(input logic wide);
        return wide ? HI_WIDE : HI_NARROW;
    endfunction

    function automatic sint_t sat(input sint_t v, input logic wide);
        sint_t hi;
        sint_t lo;
        hi = pos_bound(wide);
        lo = -hi - sint_t'(1);
        if (v > hi)      return hi;
        else if (v < lo) return lo;
        else             return v;
    endfunction

    function automatic pix_t clamp_pix(input sint_t v, input logic wide);
        sint_t top;
        top = wide ? PIX_MAX_W : PIX_MAX_N;
        if (v < sint_t'(0))  return '0;
        else if (v > top)    return top[PIX_W-1:0];
        else                 return v[PIX_W-1:0];
    endfunction
endpackage

// File: rtl/edge4_term.sv
module edge4_term
    import edge4_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  logic  wide,
    input  logic  hev,
    input  logic  en,
    input  pix_t  p1,
    input  pix_t  p0,
    input  pix_t  q0,
    input  pix_t  q1,
    output term_t term_o
);
    term_t t_d, t_q;

    always_comb begin
        sint_t base;
        sint_t diff;
        sint_t acc;
        base = hev ? sat(widen(p1) - widen(q1), wide) : sint_t'(0);
        diff = widen(q0) - widen(p0);
        acc  = sat(diff + diff + diff + base, wide);
        t_d.vld  = in_valid;
        t_d.wide = wide;
        t_d.hev  = hev;
        t_d.f    = en ? acc : sint_t'(0);
        t_d.p1   = p1;
        t_d.p0   = p0;
        t_d.q0   = q0;
        t_d.q1   = q1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign term_o = t_q;

    // R2: the registered term stays inside the signed bound of its mode
    a_r2_term_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        t_q.vld |-> (t_q.f <= pos_bound(t_q.wide)) && (t_q.f >= -pos_bound(t_q.wide) - sint_t'(1)));
endmodule

// File: rtl/edge4_apply.sv
module edge4_apply
    import edge4_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  term_t    term_i,
    output pix_set_t set_o
);
    pix_set_t s_d, s_q;

    always_comb begin
        sint_t hi;
        sint_t up4;
        sint_t up3;
        sint_t f1;
        sint_t f2;
        sint_t half;
        hi   = pos_bound(term_i.wide);
        up4  = term_i.f + sint_t'(4);
        up3  = term_i.f + sint_t'(3);
        if (up4 > hi) up4 = hi;
        if (up3 > hi) up3 = hi;
        f1   = up4 >>> SHIFT_F;
        f2   = up3 >>> SHIFT_F;
        half = (f1 + sint_t'(1)) >>> 1;
        s_d.vld  = term_i.vld;
        s_d.wide = term_i.wide;
        s_d.q0   = clamp_pix(widen(term_i.q0) - f1, term_i.wide);
        s_d.p0   = clamp_pix(widen(term_i.p0) + f2, term_i.wide);
        if (term_i.hev) begin
            s_d.p1 = term_i.p1;
            s_d.q1 = term_i.q1;
        end else begin
            s_d.p1 = clamp_pix(widen(term_i.p1) + half, term_i.wide);
            s_d.q1 = clamp_pix(widen(term_i.q1) - half, term_i.wide);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign set_o = s_q;

    // R6: with variance flagged, outer pixels leave exactly as they entered
    a_r6_outer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $past(term_i.vld && term_i.hev) |-> (s_q.p1 == $past(term_i.p1)) && (s_q.q1 == $past(term_i.q1)));

    // R7: narrow-mode results never exceed the narrow pixel maximum
    a_r7_narrow_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.vld && !s_q.wide) |-> (widen(s_q.p1) <= PIX_MAX_N) && (widen(s_q.p0) <= PIX_MAX_N)
                                 && (widen(s_q.q0) <= PIX_MAX_N) && (widen(s_q.q1) <= PIX_MAX_N));
endmodule

// File: rtl/edge4_filter.sv
module edge4_filter
    import edge4_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             mode12,
    input  logic             hev,
    input  logic             enable,
    input  logic [PIX_W-1:0] p1_i,
    input  logic [PIX_W-1:0] p0_i,
    input  logic [PIX_W-1:0] q0_i,
    input  logic [PIX_W-1:0] q1_i,
    output logic             out_valid,
    output logic [PIX_W-1:0] p1_o,
    output logic [PIX_W-1:0] p0_o,
    output logic [PIX_W-1:0] q0_o,
    output logic [PIX_W-1:0] q1_o
);
    term_t    term_w;
    pix_set_t set_w;

    edge4_term u_term (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .wide     (mode12),
        .hev      (hev),
        .en       (enable),
        .p1       (p1_i),
        .p0       (p0_i),
        .q0       (q0_i),
        .q1       (q1_i),
        .term_o   (term_w)
    );

    edge4_apply u_apply (
        .clk    (clk),
        .rst_n  (rst_n),
        .term_i (term_w),
        .set_o  (set_w)
    );

    assign out_valid = set_w.vld;
    assign p1_o      = set_w.p1;
    assign p0_o      = set_w.p0;
    assign q0_o      = set_w.q0;
    assign q1_o      = set_w.q1;

    // R1: a valid output always traces back to a valid input two edges earlier
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R8: a bubble at the input gives a bubble two edges later
    a_r8_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && !$past(in_valid, 2)) |-> !out_valid);

    // R4: a disabled set passes through untouched
    a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(enable, 2)) |-> (p1_o == $past(p1_i, 2)) && (p0_o == $past(p0_i, 2))
                                          && (q0_o == $past(q0_i, 2)) && (q1_o == $past(q1_i, 2)));
endmodule

// File: tb/edge4_filter_test.sv
module edge4_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        mode12 = 1'b0;
    logic        hev = 1'b0;
    logic        enable = 1'b0;
    logic [11:0] p1_i = '0, p0_i = '0, q0_i = '0, q1_i = '0;
    logic        out_valid;
    logic [11:0] p1_o, p0_o, q0_o, q1_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit  vld;
        int  p1, p0, q0, q1;
        string tag;
    } exp_t;

    exp_t pipe0, pipe1;

    edge4_filter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode12(mode12),
        .hev(hev), .enable(enable), .p1_i(p1_i), .p0_i(p0_i), .q0_i(q0_i), .q1_i(q1_i),
        .out_valid(out_valid), .p1_o(p1_o), .p0_o(p0_o), .q0_o(q0_o), .q1_o(q1_o)
    );

    always #10 clk = ~clk;

    function automatic int m_sat(int v, bit w);
        int hi = w ? 2047 : 511;
        if (v > hi) return hi;
        if (v < -hi - 1) return -hi - 1;
        return v;
    endfunction

    function automatic int m_clamp(int v, bit w);
        int top = w ? 4095 : 1023;
        if (v < 0) return 0;
        if (v > top) return top;
        return v;
    endfunction

    function automatic exp_t model(bit v, bit w, bit h, bit e, int a1, int a0, int b0, int b1);
        exp_t r;
        int hi = w ? 2047 : 511;
        int base, f, f1, f2, s;
        base = h ? m_sat(a1 - b1, w) : 0;
        f = m_sat(3 * (b0 - a0) + base, w);
        if (!e) f = 0;
        f1 = ((f + 4 > hi) ? hi : f + 4) >>> 3;
        f2 = ((f + 3 > hi) ? hi : f + 3) >>> 3;
        s = (f1 + 1) >>> 1;
        r.vld = v;
        r.q0 = m_clamp(b0 - f1, w);
        r.p0 = m_clamp(a0 + f2, w);
        r.p1 = h ? a1 : m_clamp(a1 + s, w);
        r.q1 = h ? b1 : m_clamp(b1 - s, w);
        if (!e)      r.tag = "R4";
        else if (h)  r.tag = "R6/R3";
        else         r.tag = "R5/R6";
        return r;
    endfunction

    task automatic check_out();
        checks++;
        if (out_valid !== pipe1.vld) begin
            errors++;
            $display("FAIL R1/R8 out_valid actual=%0b expected=%0b", out_valid, pipe1.vld);
        end
        if (pipe1.vld) begin
            checks++;
            if (p1_o !== pipe1.p1[11:0] || p0_o !== pipe1.p0[11:0] ||
                q0_o !== pipe1.q0[11:0] || q1_o !== pipe1.q1[11:0]) begin
                errors++;
                $display("FAIL %s pixels actual=%0d,%0d,%0d,%0d expected=%0d,%0d,%0d,%0d",
                         pipe1.tag, p1_o, p0_o, q0_o, q1_o, pipe1.p1, pipe1.p0, pipe1.q0, pipe1.q1);
            end
        end
    endtask

    // drive at falling edge: check the set from two edges ago, then apply new one
    task automatic step(bit v, bit w, bit h, bit e, int a1, int a0, int b0, int b1, string tag);
        exp_t n;
        @(negedge clk);
        check_out();
        n = model(v, w, h, e, a1, a0, b0, b1);
        if (tag != "") n.tag = tag;
        pipe1 = pipe0;
        pipe0 = n;
        in_valid = v; mode12 = w; hev = h; enable = e;
        p1_i = a1[11:0]; p0_i = a0[11:0]; q0_i = b0[11:0]; q1_i = b1[11:0];
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd12345));
        pipe0 = '{0, 0, 0, 0, 0, ""};
        pipe1 = '{0, 0, 0, 0, 0, ""};
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || p1_o !== 0 || p0_o !== 0 || q0_o !== 0 || q1_o !== 0) begin
            errors++;
            $display("FAIL R1 reset actual=%0b,%0d,%0d,%0d,%0d expected=0,0,0,0,0",
                     out_valid, p1_o, p0_o, q0_o, q1_o);
        end
        rst_n = 1'b1;

        // R2 R3: saturation of base and term, 10-bit
        step(1, 0, 1, 1, 1023, 0, 1023, 0, "R2 narrow sat");
        // R2: same in 12-bit
        step(1, 1, 1, 1, 4095, 0, 4095, 0, "R2 wide sat");
        // R2: negative saturation
        step(1, 0, 1, 1, 0, 1023, 0, 1023, "R2 negative sat");
        // R7: outer clamp high and low
        step(1, 0, 0, 1, 1023, 0, 100, 1023, "R7 high clamp");
        step(1, 0, 0, 1, 0, 100, 0, 0, "R7 low clamp");
        step(1, 1, 0, 1, 4095, 0, 300, 4095, "R7 wide clamp");
        // R8: bubble in the middle
        step(0, 0, 0, 1, 5, 6, 7, 8, "R8 bubble");
        // R4: disabled pass-through
        step(1, 1, 0, 0, 4000, 10, 3000, 7, "R4 disabled");
        // R5: small step both directions
        step(1, 0, 0, 1, 500, 510, 502, 480, "R5 small");
        step(1, 1, 1, 1, 2000, 2050, 2040, 2100, "R3 hev base");

        for (int i = 0; i < 600; i++) begin
            bit w = $urandom_range(0, 1);
            int top = w ? 4095 : 1023;
            int a0 = $urandom_range(0, top);
            int sp = $urandom_range(0, 1) ? top : 64;
            int b0 = m_clamp(a0 + int'($urandom_range(0, 2 * sp)) - sp, w);
            step($urandom_range(0, 7) != 0, w, $urandom_range(0, 1),
                 $urandom_range(0, 5) != 0,
                 $urandom_range(0, top), a0, b0, $urandom_range(0, top), "");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, "R8 drain");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R8 drain");
        @(negedge clk);
        check_out();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule